// File: doc/BRIEF.md
# Two-Stage Bit-Rate Generator

This block derives the bit timing of a serial line from one reference clock. It uses two counters in series. The first counter divides the reference by a programmable 16-bit divisor and emits a one-cycle sample strobe. The second counter counts those strobes into one bit period. A source select can first pass the reference through a fixed divide-by-8 stage. The resulting bit rate is reference / (P × CD × (BD + 1)), where P is 1 or 8.

A transmitter advances one bit on each bit tick. A receiver takes its data sample on the mid tick, which falls near the centre of each bit period. Choosing divisor values for a given rate belongs to software. Each divisor is taken up only at the terminal count of its own counter, so software can change it at any time without producing a short or stretched period.

Top module: `baud_gen2`

## Requirements
- R1: `sample_tick` is a single-cycle pulse. With the source select at 0, consecutive pulses are exactly CD clock cycles apart.
- R2: With `pre_div_sel` at 1, the reference is first divided by 8, so sample pulses are 8 × CD cycles apart.
- R3: `bit_tick` pulses once every BD+1 sample pulses, always in the same cycle as a `sample_tick`. The bit period is P × CD × (BD+1) cycles.
- R4: A `bdiv` value below 4 behaves exactly as 4. Values from 4 to 255 are used as given.
- R5: A CD of 0 stops `sample_tick` and therefore `bit_tick`. Once a non-zero CD is applied, pulses resume with the new spacing.
- R6: A change of `cd` takes effect at the end of the sample period in progress. That period keeps its old length, and the following period has the new length.
- R7: A change of `bdiv` takes effect at the next bit tick. The bit period in progress keeps its old length.
- R8: `mid_tick` pulses on sample pulse number floor(BD/2)+1 of each bit period (counting from 1). The first mid tick after reset therefore comes P × CD × (floor(BD/2)+1) cycles after reset.
- R9: While `rst` is high, all three outputs are 0. After release, the first sample pulse appears P × CD cycles later and the first bit tick P × CD × (BD+1) cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| cd | input | 16 | Sample divisor; 0 halts the generator |
| bdiv | input | 8 | Bit divisor; bit period spans bdiv+1 samples |
| pre_div_sel | input | 1 | 1 selects the reference divided by 8 |
| sample_tick | output | 1 | One-cycle pulse per sample period |
| bit_tick | output | 1 | One-cycle pulse at the end of each bit period |
| mid_tick | output | 1 | One-cycle pulse at the receiver sample point |

## Verification
A sample counter that runs past its divisor, or a divisor latched at the wrong moment, shows up at the ports within one sample period: the spacing of `sample_tick` changes. A wrong bit index or bit divisor shows up within one bit period, as a displaced `bit_tick` or `mid_tick`. The bench therefore times the first pulses after reset and the gaps between consecutive pulses. It changes each divisor in the middle of a period to see which period length takes the change. It holds CD at 0 long enough to see that pulses are absent rather than merely late.

// File: rtl/baud_gen2_pkg.sv
package baud_gen2_pkg;

    localparam int unsigned CD_WIDTH_DEF  = 16;
    localparam int unsigned BD_WIDTH_DEF  = 8;
    localparam int unsigned PRE_RATIO_DEF = 8;
    localparam int unsigned BD_FLOOR_DEF  = 4;

    typedef enum logic {
        SRC_DIRECT = 1'b0,
        SRC_DIV    = 1'b1
    } src_sel_e;

    typedef struct packed {
        logic sample;
        logic bit_end;
        logic mid;
    } tick_bundle_t;

endpackage

// File: rtl/baud_prescale.sv
module baud_prescale
    import baud_gen2_pkg::*;
#(
    parameter int unsigned RATIO = PRE_RATIO_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic sel,
    output logic en_o
);
    generate
        if (RATIO > 1) begin : g_div
            localparam int unsigned PW = $clog2(RATIO);
            localparam logic [PW-1:0] LAST = PW'(RATIO - 1);
            logic [PW-1:0] cnt;

            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt <= '0;
                end else if (cnt == LAST) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end

            assign en_o = (src_sel_e'(sel) == SRC_DIRECT) || (cnt == LAST);

            // divided source never yields two enables in a row
            assert_div_spacing_R2: assert property (@(posedge clk) disable iff (rst)
                (sel && $past(sel) && $past(en_o)) |-> !en_o);
        end else begin : g_pass
            assign en_o = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/baud_sample_div.sv
module baud_sample_div
    import baud_gen2_pkg::*;
#(
    parameter int unsigned CW = CD_WIDTH_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [CW-1:0] cd,
    output logic          strobe_o,
    output logic          tick_o
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] act;
    logic          halted;
    logic          term;
    logic          reload;

    assign halted   = (act == '0);
    assign term     = !halted && (cnt == act - 1'b1);
    assign strobe_o = en && term;
    assign reload   = en && (term || halted);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            act    <= cd;
            tick_o <= 1'b0;
        end else begin
            tick_o <= strobe_o;
            if (reload) begin
                cnt <= '0;
                act <= cd;
            end else if (en) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (rst)
        !halted |-> (cnt < act));

    assert_tick_width_R1: assert property (@(posedge clk) disable iff (rst)
        (tick_o && act > 1) |=> !tick_o);

    assert_cd_held_R6: assert property (@(posedge clk) disable iff (rst)
        !reload |=> $stable(act));
endmodule

// File: rtl/baud_bit_div.sv
module baud_bit_div
    import baud_gen2_pkg::*;
#(
    parameter int unsigned BW    = BD_WIDTH_DEF,
    parameter int unsigned FLOOR = BD_FLOOR_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strobe,
    input  logic [BW-1:0] bdiv,
    output logic          bit_o,
    output logic          mid_o
);
    localparam logic [BW-1:0] MINV = BW'(FLOOR);

    logic [BW-1:0] idx;
    logic [BW-1:0] act;
    logic [BW-1:0] bd_eff;
    logic          last;
    logic          midp;

    assign bd_eff = (bdiv < MINV) ? MINV : bdiv;
    assign last   = (idx == act);
    assign midp   = (idx == (act >> 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            idx   <= '0;
            act   <= bd_eff;
            bit_o <= 1'b0;
            mid_o <= 1'b0;
        end else begin
            bit_o <= strobe && last;
            mid_o <= strobe && midp;
            if (strobe) begin
                if (last) begin
                    idx <= '0;
                    act <= bd_eff;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    assert_index_bound_R3: assert property (@(posedge clk) disable iff (rst)
        idx <= act);

    assert_bd_floor_R4: assert property (@(posedge clk) disable iff (rst)
        act >= MINV);

    assert_bd_held_R7: assert property (@(posedge clk) disable iff (rst)
        !(strobe && last) |=> $stable(act));
endmodule

// File: rtl/baud_gen2.sv
module baud_gen2
    import baud_gen2_pkg::*;
#(
    parameter int unsigned CD_W      = CD_WIDTH_DEF,
    parameter int unsigned BD_W      = BD_WIDTH_DEF,
    parameter int unsigned PRE_RATIO = PRE_RATIO_DEF,
    parameter int unsigned BD_MIN    = BD_FLOOR_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [CD_W-1:0] cd,
    input  logic [BD_W-1:0] bdiv,
    input  logic            pre_div_sel,
    output logic            sample_tick,
    output logic            bit_tick,
    output logic            mid_tick
);
    logic         src_en;
    logic         smp_strobe;
    tick_bundle_t ticks;

    baud_prescale #(.RATIO(PRE_RATIO)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .sel  (pre_div_sel),
        .en_o (src_en)
    );

    baud_sample_div #(.CW(CD_W)) u_smp (
        .clk      (clk),
        .rst      (rst),
        .en       (src_en),
        .cd       (cd),
        .strobe_o (smp_strobe),
        .tick_o   (ticks.sample)
    );

    baud_bit_div #(.BW(BD_W), .FLOOR(BD_MIN)) u_bit (
        .clk    (clk),
        .rst    (rst),
        .strobe (smp_strobe),
        .bdiv   (bdiv),
        .bit_o  (ticks.bit_end),
        .mid_o  (ticks.mid)
    );

    assign sample_tick = ticks.sample;
    assign bit_tick    = ticks.bit_end;
    assign mid_tick    = ticks.mid;

    assert_bit_on_sample_R3: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> sample_tick);

    assert_mid_on_sample_R8: assert property (@(posedge clk) disable iff (rst)
        mid_tick |-> sample_tick);

    assert_mid_apart_R8: assert property (@(posedge clk) disable iff (rst)
        !(bit_tick && mid_tick));
endmodule

// File: tb/baud_gen2_test.sv
module baud_gen2_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cd = 16'd1;
    logic [7:0]  bdiv = 8'd4;
    logic        pre_div_sel = 1'b0;
    logic        sample_tick, bit_tick, mid_tick;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    baud_gen2 uut (
        .clk(clk), .rst(rst), .cd(cd), .bdiv(bdiv), .pre_div_sel(pre_div_sel),
        .sample_tick(sample_tick), .bit_tick(bit_tick), .mid_tick(mid_tick)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int eff_bd(input int b);
        return (b < 4) ? 4 : b;
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R9: outputs quiet during reset
        check(!sample_tick && !bit_tick && !mid_tick, "R9 reset quiet",
              {sample_tick, bit_tick, mid_tick}, 0);
        rst = 1'b0;
    endtask

    task automatic wait_sample(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!sample_tick && n < 100000);
    endtask

    task automatic wait_bit(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!bit_tick && n < 100000);
    endtask

    task automatic run_cfg(input int c, input int b, input bit s, input string tag);
        int p, bb, s1, s2, b1, b2, m1, lim;
        bit prev, dbl;
        cd = 16'(c); bdiv = 8'(b); pre_div_sel = s;
        do_reset();
        p = c * (s ? 8 : 1);
        bb = eff_bd(b);
        s1 = -1; s2 = -1; b1 = -1; b2 = -1; m1 = -1;
        prev = 1'b0; dbl = 1'b0;
        lim = p * (bb + 1) * 2 + 5;
        for (int t = 1; t <= lim && b2 < 0; t++) begin
            @(negedge clk);
            if (sample_tick) begin
                if (prev && p > 1) dbl = 1'b1;
                if (s1 < 0) s1 = t; else if (s2 < 0) s2 = t;
            end
            prev = sample_tick;
            if (bit_tick) begin
                if (b1 < 0) b1 = t; else if (b2 < 0) b2 = t;
            end
            if (mid_tick && m1 < 0) m1 = t;
        end
        check(s1 == p, {tag, " R9 first sample"}, s1, p);
        check(s2 - s1 == p, {tag, " R1 sample spacing"}, s2 - s1, p);
        check(!dbl, {tag, " R1 single-cycle pulse"}, dbl, 0);
        check(b1 == p * (bb + 1), {tag, " R3 first bit"}, b1, p * (bb + 1));
        check(b2 - b1 == p * (bb + 1), {tag, " R3 bit spacing"}, b2 - b1, p * (bb + 1));
        check(m1 == p * (bb / 2 + 1), {tag, " R8 mid point"}, m1, p * (bb / 2 + 1));
    endtask

    initial begin
        int n, cnt_s, cnt_b;
        int unsigned seed_v;

        run_cfg(3, 4, 1'b0, "base");
        run_cfg(2, 5, 1'b1, "R2 div8");
        run_cfg(1, 7, 1'b1, "R2 div8 cd1");
        run_cfg(5, 0, 1'b0, "R4 bd0");
        run_cfg(2, 3, 1'b0, "R4 bd3");
        run_cfg(1, 255, 1'b0, "R3 bd255");
        run_cfg(1, 4, 1'b0, "R1 cd1");

        // R5: zero divisor halts, then resumes
        cd = 16'd0; bdiv = 8'd4; pre_div_sel = 1'b0;
        do_reset();
        cnt_s = 0; cnt_b = 0;
        repeat (400) begin
            @(negedge clk);
            if (sample_tick) cnt_s++;
            if (bit_tick) cnt_b++;
        end
        check(cnt_s == 0, "R5 no sample with cd 0", cnt_s, 0);
        check(cnt_b == 0, "R5 no bit with cd 0", cnt_b, 0);
        cd = 16'd4;
        wait_sample(n);
        check(n <= 6, "R5 resumes", n, 5);
        wait_sample(n);
        check(n == 4, "R5 new spacing", n, 4);

        // R6: cd change mid-period
        cd = 16'd10; bdiv = 8'd4; pre_div_sel = 1'b0;
        do_reset();
        wait_sample(n);
        repeat (3) @(negedge clk);
        cd = 16'd3;
        wait_sample(n);
        check(n == 7, "R6 old period kept", n, 7);
        wait_sample(n);
        check(n == 3, "R6 new period", n, 3);

        // R7: bdiv change mid-bit
        cd = 16'd2; bdiv = 8'd6; pre_div_sel = 1'b0;
        do_reset();
        wait_bit(n);
        check(n == 14, "R7 first bit", n, 14);
        repeat (2) @(negedge clk);
        bdiv = 8'd4;
        wait_bit(n);
        check(n == 12, "R7 old bit kept", n, 12);
        wait_bit(n);
        check(n == 10, "R7 new bit length", n, 10);

        // random configurations
        seed_v = 32'd2024;
        void'($urandom(seed_v));
        for (int i = 0; i < 8; i++) begin
            int rc, rb;
            bit rs;
            rc = 1 + int'($urandom % 12);
            rb = int'($urandom % 13);
            rs = 1'($urandom % 2);
            run_cfg(rc, rb, rs, $sformatf("rand%0d", i));
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1 actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule